// File: doc/BRIEF.md
# Manual Pattern-Triggered Word Aligner

This block takes a parallel receive word stream whose word boundary is unknown. It keeps the two most recent words as a bit window, with the oldest bit lowest. Each cycle it compares every bit offset of that window against a programmable alignment pattern. When a command allows it, the block locks the output word boundary to the lowest offset where the pattern appears. It then delivers words cut at that boundary.

A registered hit flag reports a match at the boundary in use. A sync flag gives a one-cycle pulse a fixed three cycles after the hit flag of every lock. How the command is read depends on the word width. At 10 bits it is level-sensitive: every matching cycle while it is held re-locks. At any other width only a rising edge arms a single re-lock, and that arm waits for the next match. One instance serves one channel. Symbol decoding and automatic loss-of-sync handling are not part of this block.

Top module: `mwa_aligner`

## Requirements
- R1: Synchronous active-high reset clears the output word, the hit flag, the sync flag, the pending command state and the boundary. After reset the boundary is offset 0.
- R2: The output word is bits [o+W-1:o] of the window {previous input word, input word before it}, where o is the boundary in effect. It appears one cycle after that window is formed, so a word entering at edge n leaves at edge n+1.
- R3: The hit flag is high for one output word exactly when the low PLEN bits of that word equal the low PLEN bits of the pattern input.
- R4: On a lock, the boundary takes the matching offset for that same output word. The hit flag is therefore high together with the first word cut at the new boundary.
- R5: When several offsets 0..W-1 match in one window, the lock takes the lowest one.
- R6: With W equal to 10, the command is sampled through one register and enables a lock in every cycle it was high.
- R7: With any other W, a rising edge of the registered command arms one lock. The arm persists until the next match and is consumed by it. A command held high causes no further lock.
- R8: While no lock is enabled, the boundary is held, even if the pattern appears at a different offset.
- R9: Each lock produces a single-cycle sync pulse exactly three cycles after the hit flag of that lock. This includes a lock to the boundary already in use.
- R10: The pattern is a run-time input port, and its compared length PLEN (at most W) is a parameter.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Parallel word clock |
| rst | input | 1 | Synchronous reset, active high |
| rx_word_i | input | W | Unaligned received word, oldest bit in bit 0 |
| align_req_i | input | 1 | Realign command |
| pattern_i | input | PLEN | Alignment pattern to search for |
| word_o | output | W | Word cut at the current boundary |
| pat_hit_o | output | 1 | Pattern found at the boundary of this word |
| sync_o | output | 1 | One-cycle pulse three cycles after a lock's hit flag |

## Verification
The assertions check several rules on every cycle. A sync pulse is always preceded by a hit flag three cycles earlier. A lock always raises the hit flag on the next word. The boundary cannot move without an enabled search. The offset chosen is the lowest matching one. In edge mode a second lock requires a fresh rising edge. In level mode a lock requires the command to have been high. Only the bench scenarios can show the actual data path. They cover the cut word contents at extreme offsets 0 and W-1, a window holding two matches, reset clearing the boundary, and the contrast between a held command in the two width modes.

// File: rtl/mwa_pkg.sv
package mwa_pkg;

  // Cycles from the hit flag of a lock to its sync pulse.
  localparam int SYNC_LAT = 3;

  typedef enum logic {
    CMD_EDGE  = 1'b0,
    CMD_LEVEL = 1'b1
  } cmd_mode_e;

  // The command is level-sensitive only for a 10-bit word.
  function automatic cmd_mode_e mode_for_width(input int w);
    return (w == 10) ? CMD_LEVEL : CMD_EDGE;
  endfunction

  function automatic int offset_bits(input int w);
    return (w <= 2) ? 1 : $clog2(w);
  endfunction

endpackage

// File: rtl/mwa_cmd.sv
module mwa_cmd
  import mwa_pkg::*;
#(
  parameter cmd_mode_e MODE = CMD_LEVEL
) (
  input  logic clk,
  input  logic rst,
  input  logic align_i,
  input  logic lock_i,
  output logic srch_o
);

  logic align_q;

  always_ff @(posedge clk) begin
    if (rst) align_q <= 1'b0;
    else     align_q <= align_i;
  end

  if (MODE == CMD_LEVEL) begin : g_lvl
    assign srch_o = align_q;

    // R6: a lock needs the command high in the previous sample
    a_r6_level_gate: assert property (@(posedge clk) disable iff (rst)
      lock_i |-> $past(align_i));
  end else begin : g_edge
    logic align_qq;
    logic armed_q;
    logic rise;

    assign rise   = align_q & ~align_qq;
    assign srch_o = armed_q | rise;

    always_ff @(posedge clk) begin
      if (rst) begin
        align_qq <= 1'b0;
        armed_q  <= 1'b0;
      end else begin
        align_qq <= align_q;
        armed_q  <= (armed_q | rise) & ~lock_i;
      end
    end

    // R7: after a lock, another lock requires a new rising edge
    a_r7_one_per_edge: assert property (@(posedge clk) disable iff (rst)
      lock_i |=> (!lock_i || $rose(align_q)));
  end

endmodule

// File: rtl/mwa_match.sv
module mwa_match #(
  parameter int W    = 10,
  parameter int PLEN = W,
  parameter int OW   = 4
) (
  input  logic [W+PLEN-2:0] win_i,
  input  logic [PLEN-1:0]   pat_i,
  output logic [W-1:0]      hit_o,
  output logic              any_o,
  output logic [OW-1:0]     low_o
);

  for (genvar k = 0; k < W; k++) begin : g_cmp
    assign hit_o[k] = (win_i[k +: PLEN] == pat_i);
  end

  always_comb begin
    low_o = '0;
    for (int k = W - 1; k >= 0; k--) begin
      if (hit_o[k]) low_o = OW'(k);
    end
  end

  assign any_o = |hit_o;

endmodule

// File: rtl/mwa_dly.sv
module mwa_dly #(
  parameter int STAGES = 4
) (
  input  logic clk,
  input  logic rst,
  input  logic ev_i,
  output logic ev_o
);

  logic [STAGES-1:0] sr_q;

  always_ff @(posedge clk) begin
    if (rst) sr_q <= '0;
    else     sr_q <= {sr_q[STAGES-2:0], ev_i};
  end

  assign ev_o = sr_q[STAGES-1];

endmodule

// File: rtl/mwa_aligner.sv
module mwa_aligner
  import mwa_pkg::*;
#(
  parameter int W    = 10,
  parameter int PLEN = W
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [W-1:0]    rx_word_i,
  input  logic            align_req_i,
  input  logic [PLEN-1:0] pattern_i,
  output logic [W-1:0]    word_o,
  output logic            pat_hit_o,
  output logic            sync_o
);

  localparam int        OW   = offset_bits(W);
  localparam cmd_mode_e MODE = mode_for_width(W);

  logic [W-1:0]   d1_q, d2_q;
  logic [2*W-1:0] win;
  logic [W-1:0]   hit;
  logic           any;
  logic [OW-1:0]  low;
  logic           srch;
  logic           lock_ev;
  logic [OW-1:0]  off_q;
  logic [OW-1:0]  eff_off;

  // Word starting at bit o of the two-word window.
  function automatic logic [W-1:0] word_at(input logic [2*W-1:0] v,
                                           input logic [OW-1:0] o);
    return W'(v >> o);
  endfunction

  always_ff @(posedge clk) begin
    if (rst) begin
      d1_q <= '0;
      d2_q <= '0;
    end else begin
      d1_q <= rx_word_i;
      d2_q <= d1_q;
    end
  end

  assign win = {d1_q, d2_q};

  mwa_match #(.W(W), .PLEN(PLEN), .OW(OW)) match_i (
    .win_i (win[W+PLEN-2:0]),
    .pat_i (pattern_i),
    .hit_o (hit),
    .any_o (any),
    .low_o (low)
  );

  mwa_cmd #(.MODE(MODE)) cmd_i (
    .clk     (clk),
    .rst     (rst),
    .align_i (align_req_i),
    .lock_i  (lock_ev),
    .srch_o  (srch)
  );

  assign lock_ev = srch & any;
  assign eff_off = lock_ev ? low : off_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      off_q     <= '0;
      word_o    <= '0;
      pat_hit_o <= 1'b0;
    end else begin
      off_q     <= eff_off;
      word_o    <= word_at(win, eff_off);
      pat_hit_o <= hit[eff_off];
    end
  end

  mwa_dly #(.STAGES(SYNC_LAT + 1)) dly_i (
    .clk  (clk),
    .rst  (rst),
    .ev_i (lock_ev),
    .ev_o (sync_o)
  );

  // R3: a hit flag is always backed by a match in the prior window
  a_r3_hit_has_match: assert property (@(posedge clk) disable iff (rst)
    pat_hit_o |-> $past(any));

  // R4: a lock raises the hit flag on the first re-cut word
  a_r4_lock_flags: assert property (@(posedge clk) disable iff (rst)
    lock_ev |=> pat_hit_o);

  // R5: the matcher reports the lowest matching offset
  a_r5_lowest_pick: assert property (@(posedge clk) disable iff (rst)
    any |-> (hit[low] && ((hit & ((W'(1) << low) - W'(1))) == '0)));

  // R8: the boundary moves only under an enabled search
  a_r8_hold_boundary: assert property (@(posedge clk) disable iff (rst)
    !srch |=> $stable(off_q));

  // R9: every sync pulse trails a hit flag by three cycles
  a_r9_sync_after_hit: assert property (@(posedge clk) disable iff (rst)
    sync_o |-> $past(pat_hit_o, 3));

endmodule

// File: tb/mwa_aligner_tb_top.sv
`timescale 1ns/1ps
module mwa_aligner_tb_top;

  localparam int PAT_L = 10'h17C;
  localparam int PAT_E = 8'h3C;

  // Row: {dut select (1 = 8-bit edge unit), first shift, second shift, command mask}
  localparam logic [22:0] ROWS [10] = '{
    {1'b0, 4'd3,  4'd3,  14'h3FFF},  // relock at same boundary (R9)
    {1'b0, 4'd7,  4'd2,  14'h3FFF},  // relock to new boundary
    {1'b0, 4'd5,  4'd8,  14'h0000},  // command idle: hold (R8)
    {1'b0, 4'd8,  4'd4,  14'h3FC0},  // only second pattern taken
    {1'b0, 4'd10, 4'd1,  14'h3FFF},  // offsets 0 and 9
    {1'b0, 4'd1,  4'd10, 14'h3FFF},
    {1'b1, 4'd3,  4'd6,  14'h3FFF},  // held command, one lock only (R7)
    {1'b1, 4'd5,  4'd5,  14'h0004},  // short pulse arms a later lock
    {1'b1, 4'd2,  4'd7,  14'h00C0},
    {1'b1, 4'd8,  4'd1,  14'h0000}
  };

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [9:0] din_l = '0;
  logic [7:0] din_e = '0;
  logic al_l = 1'b0, al_e = 1'b0;
  logic [9:0] pat_l = PAT_L[9:0];
  logic [5:0] pat_e = PAT_E[5:0];
  logic [9:0] word_l;
  logic [7:0] word_e;
  logic hit_l, hit_e, sync_l, sync_e;

  int n_chk = 0;
  int n_bad = 0;
  int off_l = 0, off_e = 0;
  bit armed_e = 1'b0, prev_e = 1'b0;

  always #2.5 clk = ~clk;

  mwa_aligner #(.W(10), .PLEN(10)) dut_i (
    .clk(clk), .rst(rst), .rx_word_i(din_l), .align_req_i(al_l),
    .pattern_i(pat_l), .word_o(word_l), .pat_hit_o(hit_l), .sync_o(sync_l));

  mwa_aligner #(.W(8), .PLEN(6)) dut_e (
    .clk(clk), .rst(rst), .rx_word_i(din_e), .align_req_i(al_e),
    .pattern_i(pat_e), .word_o(word_e), .pat_hit_o(hit_e), .sync_o(sync_e));

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  task automatic run_row(input logic [22:0] r);
    bit sel = r[22];
    int sa = int'(r[21:18]);
    int sb = int'(r[17:14]);
    logic [13:0] m = r[13:0];
    int ww = sel ? 8 : 10;
    int tw[15];
    bit lk4 = 1'b0, lk9 = 1'b0, pd5, pd10;
    int o0, o1, o2;
    string lbl;
    for (int i = 0; i < 15; i++) tw[i] = 0;
    tw[4] = sel ? PAT_E : PAT_L;
    tw[9] = tw[4];
    tw[6] = 1;
    tw[7] = 3;
    if (!sel) begin
      lk4 = m[4];
      lk9 = m[9];
      prev_e = 1'b0;
    end else begin
      for (int n = 0; n < 14; n++) begin
        if (m[n] && !prev_e) armed_e = 1'b1;
        prev_e = m[n];
        if (n == 4) begin lk4 = armed_e; armed_e = 1'b0; end
        if (n == 9) begin lk9 = armed_e; armed_e = 1'b0; end
      end
    end
    o0 = sel ? off_e : off_l;
    pd5 = lk4 || (o0 == ww - sa);
    o1 = lk4 ? ww - sa : o0;
    pd10 = lk9 || (o1 == ww - sb);
    o2 = lk9 ? ww - sb : o1;
    lbl = sel ? "R7 edge-cmd" : "R6 level-cmd";
    for (int n = 0; n < 15; n++) begin
      @(negedge clk);
      if (n > 0) begin
        int e = n - 1;
        logic [31:0] w = sel ? 32'(word_e) : 32'(word_l);
        logic h = sel ? hit_e : hit_l;
        logic s = sel ? sync_e : sync_l;
        bit xh = (e == 5) ? pd5 : (e == 10) ? pd10 : 1'b0;
        bit xs = (e == 8 && lk4) || (e == 13 && lk9);
        if (e == 5 || e == 10)
          chk($sformatf("%s %s R3 hit e=%0d", lbl, ((e == 5) ? lk4 : lk9) ? "R4" : "R8", e), h, xh);
        else
          chk($sformatf("R3 hit idle e=%0d", e), h, xh);
        chk($sformatf("R9 sync e=%0d", e), s, xs);
        if (e >= 5 && e <= 7 && o1 == ww - sa)
          chk($sformatf("R2 word e=%0d", e), w, tw[e-1]);
        if (e >= 10 && o2 == ww - sb)
          chk($sformatf("R2 R4 word e=%0d", e), w, tw[e-1]);
      end
      if (n < 14) begin
        int s = (n < 7) ? sa : sb;
        logic [31:0] v = ((tw[n+1] << ww) | tw[n]) >> s;
        v = v & ((32'd1 << ww) - 1);
        if (sel) begin
          din_e = v[7:0]; al_e = m[n]; din_l = '0; al_l = 1'b0;
        end else begin
          din_l = v[9:0]; al_l = m[n]; din_e = '0; al_e = 1'b0;
        end
      end
    end
    if (sel) off_e = o2; else off_l = o2;
  endtask

  initial begin
    #(5.0 * 200000);
    n_bad++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 reset word", 32'(word_l), 0);
    chk("R1 reset hit", hit_l, 0);
    chk("R1 reset sync", sync_e, 0);
    rst = 1'b0;

    foreach (ROWS[i]) run_row(ROWS[i]);

    // R5 / R10: pattern 6'b010001 present at offsets 1 and 5 of one window
    @(negedge clk);
    pat_e = 6'h11;
    for (int n = 0; n < 10; n++) begin
      logic [7:0] seq [10] = '{8'h00, 8'h00, 8'h22, 8'h02, 8'hA5, 8'h00, 8'h00, 8'h00, 8'h00, 8'h00};
      din_e = seq[n];
      al_e = (n >= 1 && n <= 4);
      @(negedge clk);
      if (n == 4) begin
        chk("R5 R10 hit at lowest", hit_e, 1);
        chk("R5 word at lowest", 32'(word_e), 8'h11);
      end
      if (n == 5) chk("R5 next word cut at offset 1", 32'(word_e), 8'h81);
      if (n == 6) chk("R9 no early sync", sync_e, 0);
      if (n == 7) chk("R9 sync after lowest lock", sync_e, 1);
    end
    pat_e = PAT_E[5:0];
    prev_e = 1'b0;

    // R1: reset mid-run clears outputs and the boundary
    rst = 1'b1;
    din_l = '0; din_e = '0; al_l = 1'b0; al_e = 1'b0;
    repeat (2) @(negedge clk);
    chk("R1 mid reset word", 32'(word_e), 0);
    chk("R1 mid reset hit", hit_e, 0);
    chk("R1 mid reset sync", sync_l, 0);
    rst = 1'b0;
    off_l = 0; off_e = 0; armed_e = 1'b0; prev_e = 1'b0;
    // R1: idle command, stream at offset 0 is hit only if reset left offset 0
    run_row({1'b0, 4'd10, 4'd10, 14'h0000});

    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

endmodule